// File: doc/BRIEF.md
# Wiper Command and Register Controller

This block sits behind a serial front end and acts on the 16-bit command frames that front end delivers. It holds the 10-bit wiper position, a 3-bit control register and a power-down flag. For every frame it also prepares the word to be shifted out during the following frame. That word is either a requested readback or an echo of the frame just received, so devices can be chained. A completion flag drops while a write or read executes and rises again when the work is done.

A rising edge on a separate hardware reset input returns the wiper to midscale. Wiper writes stay locked out until software sets the write-enable bit in the control register. The midscale command and the hardware reset work whether or not writes are enabled.

Top module: `wiper_cmd_ctrl`

## Requirements
- R1: After the asynchronous reset, wiper_code is 512 (midscale), the control register is 0 (so cal_enable is 0 and wiper writes are locked), power_down is 0, resp_word is 0 and rdy is 1.
- R2: A frame is taken on a clock edge where frame_valid is 1. The command is in frame bits 13:10 and the data is in bits 9:0. Bits 15:14 do not affect any register except the echoed response.
- R3: Command 0001 loads data bits 9:0 into the wiper when control bit 1 is 1. When control bit 1 is 0, the wiper keeps its value.
- R4: Command 0100 loads midscale (512) into the wiper whether or not control bit 1 is set.
- R5: Command 0110 loads data bits 2:0 into the control register. Bit 1 is the wiper write enable, and bit 2 drives cal_enable.
- R6: Command 0010 sets resp_word to the zero-extended wiper value held before the frame. Command 0111 sets resp_word to the zero-extended control register. The result is visible in the cycle after the frame.
- R7: Every other frame, including undefined codes, sets resp_word to a copy of the whole received frame.
- R8: Command 1000 sets power_down to data bit 0 (1 = powered down, 0 = normal).
- R9: Commands 0001, 0010, 0110 and 0111 drive rdy low for EXEC_CYCLES cycles starting in the cycle after the frame; the protected 0001 case is included. A new such frame restarts the full count.
- R10: Commands 0000, 0100, 1000 and the undefined codes leave rdy unchanged. Undefined codes change no register other than resp_word.
- R11: A low-to-high transition of hw_reset_in loads midscale into the wiper SYNC_STAGES+1 clocks later. In that cycle it has priority over a wiper write frame. Holding the input high or lowering it has no further effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe marking a complete frame |
| frame_data | input | 16 | Received frame |
| hw_reset_in | input | 1 | Asynchronous hardware reset request, acts on rising edge |
| wiper_code | output | 10 | Current wiper position |
| power_down | output | 1 | 1 = A terminal open and wiper tied to B |
| cal_enable | output | 1 | Resistor tolerance calibration select (control bit 2) |
| resp_word | output | 16 | Word to shift out during the next frame |
| rdy | output | 1 | High when no write or read is executing |

## Verification
The bench goes after the write lock. A design that ignores the lock would move the wiper on a 0001 frame sent before 0x1802. A design that applies the lock to the wrong commands would leave the wiper off midscale after a protected 0100.

Readback is checked against the value held before the frame. A design that samples after its own update, or that returns the echo instead, gives a wrong resp_word.

The completion flag is timed edge by edge, including a restart in the middle of a count. Undefined codes are sent while the flag is high to catch a decoder that treats them as busy.

The hardware reset is lined up on the same edge as a wiper write to check its priority. It is then held high and lowered to confirm that only the rising edge acts.

// File: rtl/wiper_ctl_pkg.sv
package wiper_ctl_pkg;

   localparam int CMD_W        = 4;
   localparam int CTRL_WE_BIT  = 1;
   localparam int CTRL_CAL_BIT = 2;

   typedef enum logic [CMD_W-1:0] {
      CMD_NOP      = 4'b0000,
      CMD_WR_WIPER = 4'b0001,
      CMD_RD_WIPER = 4'b0010,
      CMD_MIDSCALE = 4'b0100,
      CMD_WR_CTRL  = 4'b0110,
      CMD_RD_CTRL  = 4'b0111,
      CMD_PWRDN    = 4'b1000
   } cmd_e;

   typedef struct packed {
      logic wr_wiper;
      logic rd_wiper;
      logic midscale;
      logic wr_ctrl;
      logic rd_ctrl;
      logic pwrdn;
   } dec_t;

endpackage

// File: rtl/wctl_edge_sync.sv
module wctl_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   initial begin
      assert (STAGES >= 0 && STAGES <= 8) else $fatal(1, "STAGES out of range");
   end

   logic synced;
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_bypass
         assign synced = async_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) sh_q[0] <= 1'b0;
                  else        sh_q[0] <= async_i;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) sh_q[i] <= 1'b0;
                  else        sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign synced = sh_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= synced;
   end

   assign rise_o = synced & ~prev_q;

   // R11: a held-high input yields one pulse only
   assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/wctl_decode.sv
module wctl_decode
   import wiper_ctl_pkg::*;
(
   input  logic [CMD_W-1:0] cmd_i,
   output dec_t             dec_o,
   output logic             busy_o
);

   always_comb begin
      dec_o  = '0;
      busy_o = 1'b0;
      case (cmd_i)
         CMD_WR_WIPER: begin dec_o.wr_wiper = 1'b1; busy_o = 1'b1; end
         CMD_RD_WIPER: begin dec_o.rd_wiper = 1'b1; busy_o = 1'b1; end
         CMD_MIDSCALE: dec_o.midscale = 1'b1;
         CMD_WR_CTRL:  begin dec_o.wr_ctrl = 1'b1; busy_o = 1'b1; end
         CMD_RD_CTRL:  begin dec_o.rd_ctrl = 1'b1; busy_o = 1'b1; end
         CMD_PWRDN:    dec_o.pwrdn = 1'b1;
         default:      ;
      endcase
   end

   // R10: at most one action strobe per command
   always_comb begin
      assert_one_action_R10: assert ($onehot0(dec_o));
   end

endmodule

// File: rtl/wctl_busy_timer.sv
module wctl_busy_timer #(
   parameter int EXEC_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic rdy_o
);

   initial begin
      assert (EXEC_CYCLES >= 0) else $fatal(1, "EXEC_CYCLES negative");
   end

   generate
      if (EXEC_CYCLES == 0) begin : g_instant
         assign rdy_o = 1'b1;
      end else begin : g_count
         localparam int CNT_W = $clog2(EXEC_CYCLES + 1);
         localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(EXEC_CYCLES);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (start_i)         cnt_q <= CNT_MAX;
            else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
         end

         assign rdy_o = (cnt_q == '0);

         // R9: an accepted write or read frame always lowers rdy next cycle
         assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
            start_i |=> !rdy_o);
         // R9: counter never exceeds the execution window
         assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_MAX);
         // R9: once idle, rdy stays high without a start
         assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (rdy_o && !start_i) |=> rdy_o);
      end
   endgenerate

endmodule

// File: rtl/wctl_regs.sv
module wctl_regs
   import wiper_ctl_pkg::*;
#(
   parameter int FRAME_W = 16,
   parameter int WIPER_W = 10,
   parameter int CTRL_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_valid,
   input  logic [FRAME_W-1:0] frame_i,
   input  dec_t               dec_i,
   input  logic               hw_rise_i,
   output logic [WIPER_W-1:0] wiper_o,
   output logic [CTRL_W-1:0]  ctrl_o,
   output logic               pd_o,
   output logic [FRAME_W-1:0] resp_o
);

   localparam logic [WIPER_W-1:0] MIDSCALE = WIPER_W'(1) << (WIPER_W - 1);

   initial begin
      assert (CTRL_W > CTRL_CAL_BIT) else $fatal(1, "CTRL_W too small");
      assert (WIPER_W >= CTRL_W)     else $fatal(1, "WIPER_W below CTRL_W");
      assert (FRAME_W >= WIPER_W)    else $fatal(1, "FRAME_W below WIPER_W");
   end

   logic [WIPER_W-1:0] data;
   logic [WIPER_W-1:0] wiper_q;
   logic [CTRL_W-1:0]  ctrl_q;
   logic               pd_q;
   logic [FRAME_W-1:0] resp_q;
   logic               wr_allowed;

   assign data       = frame_i[WIPER_W-1:0];
   assign wr_allowed = ctrl_q[CTRL_WE_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wiper_q <= MIDSCALE;
      end else if (hw_rise_i) begin
         wiper_q <= MIDSCALE;
      end else if (frame_valid && dec_i.midscale) begin
         wiper_q <= MIDSCALE;
      end else if (frame_valid && dec_i.wr_wiper && wr_allowed) begin
         wiper_q <= data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ctrl_q <= '0;
      else if (frame_valid && dec_i.wr_ctrl) ctrl_q <= data[CTRL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         pd_q <= 1'b0;
      else if (frame_valid && dec_i.pwrdn) pd_q <= data[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_q <= '0;
      end else if (frame_valid) begin
         if (dec_i.rd_wiper)     resp_q <= FRAME_W'(wiper_q);
         else if (dec_i.rd_ctrl) resp_q <= FRAME_W'(ctrl_q);
         else                    resp_q <= frame_i;
      end
   end

   assign wiper_o = wiper_q;
   assign ctrl_o  = ctrl_q;
   assign pd_o    = pd_q;
   assign resp_o  = resp_q;

   // R3: wiper moves only on an enabled write, midscale command or reset edge
   assert_wiper_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(hw_rise_i || (frame_valid && (dec_i.midscale || (dec_i.wr_wiper && wr_allowed))))
      |=> $stable(wiper_q));
   // R4: midscale command works even while writes are locked
   assert_midscale_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && dec_i.midscale) |=> (wiper_q == MIDSCALE));
   // R11: reset edge wins over any frame in the same cycle
   assert_hw_midscale_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hw_rise_i |=> (wiper_q == MIDSCALE));
   // R8: power-down follows data bit 0
   assert_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && dec_i.pwrdn) |=> (pd_q == $past(frame_i[0])));
   // R5: control changes only on its write command
   assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_valid && dec_i.wr_ctrl) |=> $stable(ctrl_q));

endmodule

// File: rtl/wiper_cmd_ctrl.sv
module wiper_cmd_ctrl
   import wiper_ctl_pkg::*;
#(
   parameter int FRAME_W     = 16,
   parameter int WIPER_W     = 10,
   parameter int CTRL_W      = 3,
   parameter int EXEC_CYCLES = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_valid,
   input  logic [FRAME_W-1:0] frame_data,
   input  logic               hw_reset_in,
   output logic [WIPER_W-1:0] wiper_code,
   output logic               power_down,
   output logic               cal_enable,
   output logic [FRAME_W-1:0] resp_word,
   output logic               rdy
);

   initial begin
      assert (FRAME_W >= WIPER_W + CMD_W) else $fatal(1, "frame too narrow");
   end

   logic [CMD_W-1:0]  cmd;
   dec_t              dec;
   logic              busy_cmd;
   logic              hw_rise;
   logic [CTRL_W-1:0] ctrl;

   assign cmd = frame_data[WIPER_W +: CMD_W];

   wctl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (hw_reset_in),
      .rise_o  (hw_rise)
   );

   wctl_decode u_dec (
      .cmd_i  (cmd),
      .dec_o  (dec),
      .busy_o (busy_cmd)
   );

   wctl_regs #(
      .FRAME_W (FRAME_W),
      .WIPER_W (WIPER_W),
      .CTRL_W  (CTRL_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_valid (frame_valid),
      .frame_i     (frame_data),
      .dec_i       (dec),
      .hw_rise_i   (hw_rise),
      .wiper_o     (wiper_code),
      .ctrl_o      (ctrl),
      .pd_o        (power_down),
      .resp_o      (resp_word)
   );

   wctl_busy_timer #(.EXEC_CYCLES(EXEC_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (frame_valid && busy_cmd),
      .rdy_o   (rdy)
   );

   assign cal_enable = ctrl[CTRL_CAL_BIT];

   // R10: frames outside the busy set leave an idle rdy high
   assert_quiet_rdy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && !busy_cmd && rdy) |=> rdy);

endmodule

// File: tb/tb_wiper_cmd_ctrl.sv
module tb_wiper_cmd_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int EXEC       = 8;
   localparam int SYNC       = 2;
   localparam logic [9:0] MID = 10'd512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_valid = 1'b0;
   logic [15:0] frame_data = '0;
   logic        hw_reset_in = 1'b0;
   logic [9:0]  wiper_code;
   logic        power_down;
   logic        cal_enable;
   logic [15:0] resp_word;
   logic        rdy;

   int checks = 0;
   int errors = 0;

   logic [9:0]  m_wiper;
   logic [2:0]  m_ctrl;
   logic        m_pd;
   logic [15:0] m_resp;

   always #(CLK_PERIOD/2) clk = ~clk;

   wiper_cmd_ctrl #(.EXEC_CYCLES(EXEC), .SYNC_STAGES(SYNC)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_valid (frame_valid),
      .frame_data  (frame_data),
      .hw_reset_in (hw_reset_in),
      .wiper_code  (wiper_code),
      .power_down  (power_down),
      .cal_enable  (cal_enable),
      .resp_word   (resp_word),
      .rdy         (rdy)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%0h expected=%0h", req, got, exp);
      end
   endtask

   function automatic logic [15:0] mk(input logic [3:0] cmd, input logic [9:0] d);
      return {2'b00, cmd, d};
   endfunction

   function automatic logic is_busy(input logic [3:0] cmd);
      return (cmd == 4'b0001) || (cmd == 4'b0010) || (cmd == 4'b0110) || (cmd == 4'b0111);
   endfunction

   function automatic logic [15:0] exp_resp(input logic [15:0] f, input logic [9:0] w,
                                             input logic [2:0] c);
      case (f[13:10])
         4'b0010: return {6'b0, w};
         4'b0111: return {13'b0, c};
         default: return f;
      endcase
   endfunction

   task automatic model_apply(input logic [15:0] f);
      logic [3:0] cmd;
      logic [9:0] d;
      cmd = f[13:10];
      d   = f[9:0];
      m_resp = exp_resp(f, m_wiper, m_ctrl);
      case (cmd)
         4'b0001: if (m_ctrl[1]) m_wiper = d;
         4'b0100: m_wiper = MID;
         4'b0110: m_ctrl = d[2:0];
         4'b1000: m_pd = d[0];
         default: ;
      endcase
   endtask

   // frame sampled on one edge; returns at the falling edge right after it
   task automatic send(input logic [15:0] f);
      @(negedge clk);
      frame_valid = 1'b1;
      frame_data  = f;
      @(negedge clk);
      frame_valid = 1'b0;
      frame_data  = '0;
      model_apply(f);
   endtask

   task automatic check_state(input string req);
      check({req, " wiper"}, 32'(wiper_code), 32'(m_wiper));
      check({req, " pd"},    32'(power_down), 32'(m_pd));
      check({req, " cal"},   32'(cal_enable), 32'(m_ctrl[2]));
      check({req, " resp"},  32'(resp_word),  32'(m_resp));
   endtask

   task automatic wait_idle();
      repeat (EXEC) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1D5E_0042));
      m_wiper = MID; m_ctrl = '0; m_pd = 1'b0; m_resp = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 wiper", 32'(wiper_code), 32'(MID));
      check("R1 pd",    32'(power_down), 0);
      check("R1 cal",   32'(cal_enable), 0);
      check("R1 resp",  32'(resp_word),  0);
      check("R1 rdy",   32'(rdy),        1);

      // R3 write locked: wiper unchanged, rdy still drops (R9)
      send(mk(4'b0001, 10'd100));
      check("R3 locked wiper", 32'(wiper_code), 32'(MID));
      check("R9 locked write busy", 32'(rdy), 0);
      wait_idle();
      check("R9 idle", 32'(rdy), 1);

      // R5 unlock with 0x1802, then R3 write
      send(16'h1802);
      check_state("R5 ctrl write");
      wait_idle();
      send(mk(4'b0001, 10'd100));
      check("R3 enabled write", 32'(wiper_code), 100);
      // R9 timing edge by edge
      repeat (EXEC - 1) begin
         @(negedge clk);
      end
      check("R9 last busy cycle", 32'(rdy), 0);
      @(negedge clk);
      check("R9 rdy returns", 32'(rdy), 1);

      // R9 restart mid-count
      send(mk(4'b0010, 10'd0));
      check("R6 wiper readback", 32'(resp_word), 100);
      repeat (2) @(negedge clk);
      send(mk(4'b0111, 10'd0));
      check("R6 ctrl readback", 32'(resp_word), 2);
      repeat (EXEC - 1) @(negedge clk);
      check("R9 restart still busy", 32'(rdy), 0);
      @(negedge clk);
      check("R9 restart done", 32'(rdy), 1);

      // R7 echo of NOP, R2 spare bits ignored
      send(16'hC07B);
      check("R7 echo", 32'(resp_word), 32'h0000_C07B);
      check("R2 spare bits no effect", 32'(wiper_code), 100);
      check("R10 nop rdy", 32'(rdy), 1);

      // R10 undefined codes while idle
      send(mk(4'b1011, 10'h3FF));
      check("R10 undef rdy", 32'(rdy), 1);
      check_state("R10 undef state");

      // R8 power down on and off
      send(mk(4'b1000, 10'd1));
      check("R8 pd on", 32'(power_down), 1);
      check("R10 pd cmd rdy", 32'(rdy), 1);
      send(mk(4'b1000, 10'd0));
      check("R8 pd off", 32'(power_down), 0);

      // R5 cal bit, then lock and R4 midscale while locked
      send(mk(4'b0110, 10'b100));
      check("R5 cal set", 32'(cal_enable), 1);
      wait_idle();
      send(mk(4'b0100, 10'd0));
      check("R4 midscale locked", 32'(wiper_code), 32'(MID));
      check("R10 midscale rdy", 32'(rdy), 1);

      // R11 hw reset aligned with a write frame
      send(mk(4'b0110, 10'b010));
      wait_idle();
      send(mk(4'b0001, 10'd7));
      wait_idle();
      @(negedge clk);
      hw_reset_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      frame_valid = 1'b1;
      frame_data  = mk(4'b0001, 10'd900);
      @(negedge clk);
      frame_valid = 1'b0;
      frame_data  = '0;
      model_apply(mk(4'b0001, 10'd900));
      m_wiper = MID;
      check("R11 priority over write", 32'(wiper_code), 32'(MID));
      wait_idle();
      send(mk(4'b0001, 10'd33));
      repeat (SYNC + 3) @(negedge clk);
      check("R11 level held", 32'(wiper_code), 33);
      hw_reset_in = 1'b0;
      repeat (SYNC + 3) @(negedge clk);
      check("R11 falling edge", 32'(wiper_code), 33);
      hw_reset_in = 1'b1;
      repeat (SYNC + 2) @(negedge clk);
      m_wiper = MID;
      check("R11 rise loads midscale", 32'(wiper_code), 32'(MID));
      hw_reset_in = 1'b0;
      wait_idle();

      // random frames
      for (int n = 0; n < 300; n++) begin
         logic [3:0]  cmd;
         logic [15:0] f;
         case ($urandom_range(0, 9))
            0: cmd = 4'b0000;
            1, 2: cmd = 4'b0001;
            3: cmd = 4'b0010;
            4: cmd = 4'b0100;
            5: cmd = 4'b0110;
            6: cmd = 4'b0111;
            7: cmd = 4'b1000;
            default: cmd = 4'($urandom_range(9, 15));
         endcase
         f = {2'($urandom_range(0, 3)), cmd, 10'($urandom_range(0, 1023))};
         send(f);
         check_state("R2 random frame");
         check("R9 random rdy", 32'(rdy), 32'(!is_busy(cmd)));
         if (is_busy(cmd)) wait_idle();
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule